// File: doc/BRIEF.md
# Mailbox Word Queue with Packed Status

This block holds a short first-in first-out queue of 32-bit message words for a mailbox controller. A producer offers words on the push port and a consumer pulls the oldest word through the pop port. A head output lets a reader look at the oldest word without taking it. A packed status word carries a full flag, an empty flag and the current fill level, so software can read all three with one access. Any slot that holds no message contains the all-ones word `32'hFFFF_FFFF`, which marks it as invalid. A pop from an empty queue returns that same value.

Storage is a shift-down register array. Slot 0 always holds the oldest word. A pop moves every remaining word down by one slot, and the freed top slot takes the invalid value again. A push writes the new word into the slot just above the last valid one. A small controller holds the occupancy state and the count. The occupancy state is one of `OCC_EMPTY`, `OCC_PARTIAL` or `OCC_FULL`, and it has these transitions:

- EMPTY→PARTIAL on a push.
- EMPTY→FULL on a push, only when the depth is 1.
- PARTIAL→FULL on a push that is not paired with a pop and reaches the depth.
- PARTIAL→EMPTY on a pop that is not paired with a push and takes the last word.
- FULL→PARTIAL on a pop that is not paired with a push. This becomes FULL→EMPTY when the depth is 1.
- Every other combination holds the current state.

The enclosing controller decodes the bus, routes channels and generates interrupts.

Top module: `mbox_queue`

## Requirements
- R1: Reset leaves the queue empty. The level is 0, the empty flag is set, the full flag is clear, and every slot holds `32'hFFFF_FFFF`, so the head output shows that value.
- R2: The status word has this layout. Bit 31 is the full flag. Bit 30 is the empty flag. Bits 7:0 hold the fill level. All other bits read 0.
- R3: An accepted push with no pop appends the word behind the existing words and raises the level by one.
- R4: A pop on a non-empty queue presents the oldest word on `pop_data` and asserts `pop_ok` in the same cycle. After the clock edge the remaining words have moved down one place and the level has dropped by one.
- R5: `head_word` always shows the oldest word without changing the queue, and it shows `32'hFFFF_FFFF` when the queue is empty.
- R6: A pop on an empty queue with no push returns `32'hFFFF_FFFF` with `pop_ok` low and leaves the queue unchanged.
- R7: A push on a full queue with no pop is ignored, and the contents and the status stay unchanged.
- R8: A push and a pop in the same cycle on a non-empty queue, including a full queue, complete in one cycle. The oldest word leaves, the new word joins the tail, and the level stays the same.
- R9: The full flag is set exactly when the level equals the depth (default 8). The empty flag is set exactly when the level is 0.
- R10: A push and a pop in the same cycle on an empty queue return `32'hFFFF_FFFF` with `pop_ok` low, and the pushed word is stored, so the level becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Offer `push_data` for the tail this cycle |
| push_data | input | 32 | Word to append |
| pop_req | input | 1 | Remove the oldest word this cycle |
| pop_data | output | 32 | Word removed by this cycle's pop (the invalid value when empty) |
| pop_ok | output | 1 | High when this cycle's pop removes a real word |
| head_word | output | 32 | Oldest word, shown without removal |
| status_word | output | 32 | {full, empty, 22'b0, level[7:0]} |

## Verification
The bench runs the boundaries: it fills the queue to the depth, pushes while full, drains to empty, and then pops once more. A design whose freed slots kept stale data would show an old word at the head of an empty queue, and one that wrapped its count on an overflowing push would report a tiny level with neither flag set. Paired push and pop on an empty queue and on a full queue come next. Getting the first wrong either loses the pushed word or returns a stale value. Getting the second wrong either writes the new word one slot too high or rejects it. A long pseudo-random mix then compares every word order and status word against an arithmetic model of the queue.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam logic [31:0] MB_INVALID   = 32'hFFFF_FFFF;
    localparam int          ST_FULL_BIT  = 31;
    localparam int          ST_EMPTY_BIT = 30;
    localparam int          ST_LEVEL_W   = 8;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          push_do,
    output logic          pop_do,
    output logic          is_empty,
    output logic          is_full,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_TOP = CW'(DEPTH - 1);

    occ_e          occ_q, occ_nx;
    logic [CW-1:0] cnt_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= OCC_EMPTY;
            cnt   <= '0;
        end else begin
            occ_q <= occ_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs decoded from the occupancy state
    always_comb begin
        is_empty = 1'b0;
        is_full  = 1'b0;
        push_do  = 1'b0;
        pop_do   = 1'b0;
        unique case (occ_q)
            OCC_EMPTY: begin
                is_empty = 1'b1;
                push_do  = push_req;
            end
            OCC_PARTIAL: begin
                push_do = push_req;
                pop_do  = pop_req;
            end
            OCC_FULL: begin
                is_full = 1'b1;
                pop_do  = pop_req;
                push_do = push_req && pop_req;
            end
            default: ;
        endcase
    end

    // next state and count
    always_comb begin
        occ_nx = occ_q;
        cnt_nx = cnt + CW'(push_do) - CW'(pop_do);
        unique case (occ_q)
            OCC_EMPTY: begin
                if (push_do) occ_nx = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;
            end
            OCC_PARTIAL: begin
                if (push_do && !pop_do && cnt == CNT_TOP)
                    occ_nx = OCC_FULL;
                else if (pop_do && !push_do && cnt == CW'(1))
                    occ_nx = OCC_EMPTY;
            end
            OCC_FULL: begin
                if (pop_do && !push_do)
                    occ_nx = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;
            end
            default: occ_nx = OCC_EMPTY;
        endcase
    end
endmodule

// File: rtl/mbox_store.sv
module mbox_store
    import mbox_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_do,
    input  logic          pop_do,
    input  logic [CW-1:0] cnt,
    input  logic [31:0]   wr_data,
    output logic [31:0]   head
);
    logic [31:0]   slot [DEPTH];
    logic [CW-1:0] tail_after_pop;

    assign tail_after_pop = cnt - CW'(1);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [31:0] above;
        if (i == DEPTH - 1) begin : g_top
            assign above = MB_INVALID;
        end else begin : g_mid
            assign above = slot[i+1];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[i] <= MB_INVALID;
            end else if (pop_do) begin
                if (push_do && tail_after_pop == CW'(i))
                    slot[i] <= wr_data;
                else
                    slot[i] <= above;
            end else if (push_do && cnt == CW'(i)) begin
                slot[i] <= wr_data;
            end
        end
    end

    assign head = slot[0];
endmodule

// File: rtl/mbox_status.sv
module mbox_status
    import mbox_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          is_full,
    input  logic          is_empty,
    input  logic [CW-1:0] cnt,
    output logic [31:0]   word
);
    always_comb begin
        word                        = '0;
        word[ST_FULL_BIT]           = is_full;
        word[ST_EMPTY_BIT]          = is_empty;
        word[ST_LEVEL_W-1:0]        = ST_LEVEL_W'(cnt);
    end
endmodule

// File: rtl/mbox_queue.sv
module mbox_queue
    import mbox_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_valid,
    input  logic [31:0] push_data,
    input  logic        pop_req,
    output logic [31:0] pop_data,
    output logic        pop_ok,
    output logic [31:0] head_word,
    output logic [31:0] status_word
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          push_do, pop_do, is_empty, is_full;
    logic [CW-1:0] cnt;
    logic [31:0]   head;

    mbox_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_valid),
        .pop_req  (pop_req),
        .push_do  (push_do),
        .pop_do   (pop_do),
        .is_empty (is_empty),
        .is_full  (is_full),
        .cnt      (cnt)
    );

    mbox_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_do (push_do),
        .pop_do  (pop_do),
        .cnt     (cnt),
        .wr_data (push_data),
        .head    (head)
    );

    mbox_status #(.CW(CW)) u_status (
        .is_full  (is_full),
        .is_empty (is_empty),
        .cnt      (cnt),
        .word     (status_word)
    );

    assign head_word = head;
    assign pop_data  = head;
    assign pop_ok    = pop_do;
endmodule

// File: rtl/mbox_queue_chk.sv
module mbox_queue_chk
    import mbox_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        push_valid,
    input logic [31:0] push_data,
    input logic        pop_req,
    input logic [31:0] pop_data,
    input logic        pop_ok,
    input logic [31:0] head_word,
    input logic [31:0] status_word
);
    logic       st_full, st_empty;
    logic [7:0] lvl;
    assign st_full  = status_word[31];
    assign st_empty = status_word[30];
    assign lvl      = status_word[7:0];

    p_reset_empty_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> st_empty && !st_full && lvl == 8'd0 && head_word == MB_INVALID);

    p_flag_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_full && st_empty) && status_word[29:8] == '0);

    p_push_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && !pop_req && !st_full |=> lvl == 8'($past(lvl) + 8'd1));

    p_pop_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !push_valid && !st_empty |=> lvl == 8'($past(lvl) - 8'd1));

    p_empty_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_empty |-> head_word == MB_INVALID);

    p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !push_valid && st_empty |=> $stable(status_word) && $stable(head_word));

    p_pop_empty_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && st_empty |-> !pop_ok && pop_data == MB_INVALID);

    p_full_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && !pop_req && st_full |=> $stable(status_word) && $stable(head_word));

    p_both_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && pop_req && !st_empty |=> $stable(lvl));

    p_full_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_full |-> lvl == 8'(DEPTH));

    p_both_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && pop_req && st_empty |=> lvl == 8'd1 && head_word == $past(push_data));
endmodule

bind mbox_queue mbox_queue_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/mbox_queue_bench.sv
module mbox_queue_bench;
    localparam int          DEPTH = 8;
    localparam logic [31:0] INV   = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_valid;
    logic [31:0] push_data;
    logic        pop_req;
    logic [31:0] pop_data;
    logic        pop_ok;
    logic [31:0] head_word;
    logic [31:0] status_word;

    int errs   = 0;
    int checks = 0;
    logic [31:0] mq[$];
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    mbox_queue #(.DEPTH(DEPTH)) u_mbox_queue (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        int n = mq.size();
        return {n == DEPTH, n == 0, 22'd0, 8'(n)};
    endfunction

    task automatic step(bit p, logic [31:0] d, bit q);
        string tag;
        int    n;
        bit    popd, pushd;
        @(negedge clk);
        push_valid = p;
        push_data  = d;
        pop_req    = q;
        #2;
        n = mq.size();
        if (q && n == 0 && p)      tag = "R10 push+pop on empty";
        else if (q && n == 0)      tag = "R6 pop on empty";
        else if (p && q)           tag = "R8 push+pop";
        else if (p && n == DEPTH)  tag = "R7 push on full";
        else if (p)                tag = "R3 push";
        else if (q)                tag = "R4 pop";
        else                       tag = "R5 idle peek";
        chk({tag, " pop_data"}, pop_data, (n > 0) ? mq[0] : INV);
        chk({tag, " pop_ok"}, {31'd0, pop_ok}, {31'd0, q && n > 0});
        @(posedge clk);
        popd  = q && n > 0;
        pushd = p && (n < DEPTH || popd);
        if (popd)  void'(mq.pop_front());
        if (pushd) mq.push_back(d);
        #1;
        chk((mq.size() == DEPTH || mq.size() == 0) ? {tag, " R9 status"} : {tag, " R2 status"},
            status_word, exp_status());
        chk({tag, " R5 head"}, head_word, (mq.size() > 0) ? mq[0] : INV);
        push_valid = 1'b0;
        pop_req    = 1'b0;
    endtask

    task automatic reset_check();
        @(negedge clk);
        rst_n = 1'b0;
        push_valid = 1'b0;
        pop_req = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        mq.delete();
        chk("R1 reset status", status_word, {1'b0, 1'b1, 30'd0});
        chk("R1 reset head", head_word, INV);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 150000);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        push_valid = 1'b0;
        push_data = '0;
        pop_req = 1'b0;
        reset_check();
        step(0, 0, 0);
        step(0, 0, 1);                               // R6
        step(0, 0, 1);
        for (int i = 0; i < DEPTH; i++) step(1, 32'h1000_0000 + i, 0); // R3, R9
        step(0, 0, 0);                               // R5 peek while full
        step(1, 32'hDEAD_0001, 0);                   // R7
        step(1, 32'hDEAD_0002, 0);
        step(1, 32'hBEEF_0001, 1);                   // R8 on full
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1); // R4
        step(0, 0, 1);                               // R6 after drain
        step(1, 32'h5555_AAAA, 1);                   // R10
        step(1, 32'h0000_0007, 1);                   // R8 at level 1
        for (int i = 0; i < 3; i++) step(1, 32'h2000_0000 + i, 0);
        reset_check();                               // R1 from non-empty
        for (int i = 0; i < 600; i++) begin
            bit p, q;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            p = lfsr[0] | lfsr[5];
            q = lfsr[3] & (lfsr[7] | (i > 300));
            step(p, {lfsr, ~lfsr}, q);
        end
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule